// File: doc/BRIEF.md
# JTAG Instruction Register with Live Status Capture

This block is the instruction path of a test access port. It runs its own sixteen-state TAP controller, clocked by TCK, and holds an eight-bit shift stage and a separate instruction latch. When the controller passes through Capture-IR, the shift stage loads a status word. The low bits of that word are a fixed marker and the middle bits report two live device conditions: whether the device is in in-system-configuration mode, and whether its security option is set. In Shift-IR the word leaves on TDO, least significant bit first, while the new opcode enters from TDI. The latch takes the shifted value on entry to Update-IR.

A host reads the device status by running a single instruction scan. A system controller uses the `instr` output to decode which data register the chip selects. The latch is written only on entry to Update-IR or on entry to Test-Logic-Reset, so `instr` holds steady through every shift and pause. Test-Logic-Reset loads a parameterised identification opcode.

Top module: `jir_top`

## Requirements
- R1: The word captured in Capture-IR has bits 7:5 at 0, bit 2 at 0 and bits 1:0 at 2'b01.
- R2: Captured bit 4 equals `cfg_mode` and captured bit 3 equals `secure`, both as sampled on the TCK rising edge taken in Capture-IR.
- R3: In Shift-IR, TDO first presents captured bit 0. Each rising edge moves the stage one place toward bit 0 and loads TDI into bit 7. On entry to Update-IR, `instr` takes the stage, with the earliest of the last eight TDI bits in bit 0.
- R4: In a scan longer than eight bits, TDO presents the captured word and then the TDI stream delayed by eight shifts. `instr` receives the last eight bits shifted in.
- R5: `tdo` and `tdo_en` change only on the falling edge of TCK. `tdo_en` is 1 only in Shift-IR or Shift-DR. `tdo` is 0 whenever the controller is not in Shift-IR.
- R6: `instr` changes only on entry to Update-IR or Test-Logic-Reset. It is unchanged through shifting, through Pause-IR and through a complete data-register scan.
- R7: A synchronous active-high `tap_rst` puts the controller in Test-Logic-Reset, sets `instr` to IDCODE (default 8'hFE) and drives `tdo_en` to 0.
- R8: Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state, and `instr` becomes IDCODE on that fifth edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| tap_rst | input | 1 | Synchronous active-high TAP reset |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| cfg_mode | input | 1 | Device is in in-system-configuration mode |
| secure | input | 1 | Security option is programmed on |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | TDO drive enable |
| instr | output | IR_W | Current instruction |

## Verification
The bench sweeps every eight-bit opcode through a full instruction scan and cycles all four status-flag combinations during the sweep. A design with a swapped or stale status bit would then show a wrong TDO bit, and a design that shifts MSB-first would load a bit-reversed instruction. Scans of eleven and sixteen bits catch a stage that saturates or that drops bits past the eighth. The bench samples `tdo_en` just after the rising edge that enters Shift-IR, where it must still be low, which exposes an output that is driven from the rising edge. A data-register scan and a pause inside Shift-IR would reveal a latch that updates early. A five-cycle TMS-high walk from Shift-DR would reveal an off-by-one in the reset path.

// File: rtl/jir_pkg.sv
package jir_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  function automatic tap_st_e tap_next(tap_st_e s, logic tms);
    tap_st_e n;
    unique case (s)
      ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
      default:   n = ST_TLR;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/jir_tap_fsm.sv
module jir_tap_fsm
  import jir_pkg::*;
(
  input  logic    tck,
  input  logic    rst,
  input  logic    tms,
  output tap_st_e st,
  output tap_st_e nxt
);
  assign nxt = tap_next(st, tms);

  always_ff @(posedge tck) begin
    if (rst) st <= ST_TLR;
    else     st <= nxt;
  end
endmodule

// File: rtl/jir_shift_path.sv
module jir_shift_path
  import jir_pkg::*;
#(
  parameter int IR_W = 8
) (
  input  logic            tck,
  input  logic            rst,
  input  tap_st_e         st,
  input  logic            tdi,
  input  logic            cfg_mode,
  input  logic            secure,
  output logic [IR_W-1:0] sr_q,
  output logic            tdo,
  output logic            tdo_en
);
  localparam int CFG_BIT = 4;
  localparam int SEC_BIT = 3;

  logic [IR_W-1:0] cap_word;

  always_comb begin
    cap_word          = '0;
    cap_word[1:0]     = 2'b01;
    cap_word[CFG_BIT] = cfg_mode;
    cap_word[SEC_BIT] = secure;
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      sr_q <= '0;
    end else if (st == ST_CAP_IR) begin
      sr_q <= cap_word;
    end else if (st == ST_SH_IR) begin
      sr_q <= {tdi, sr_q[IR_W-1:1]};
    end
  end

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= (st == ST_SH_IR) ? sr_q[0] : 1'b0;
      tdo_en <= (st == ST_SH_IR) || (st == ST_SH_DR);
    end
  end
endmodule

// File: rtl/jir_instr_hold.sv
module jir_instr_hold
  import jir_pkg::*;
#(
  parameter int              IR_W   = 8,
  parameter logic [IR_W-1:0] IDCODE = 8'hFE
) (
  input  logic            tck,
  input  logic            rst,
  input  tap_st_e         nxt,
  input  logic [IR_W-1:0] sr_q,
  output logic [IR_W-1:0] instr
);
  always_ff @(posedge tck) begin
    if (rst || nxt == ST_TLR) instr <= IDCODE;
    else if (nxt == ST_UPD_IR) instr <= sr_q;
  end
endmodule

// File: rtl/jir_top.sv
module jir_top
  import jir_pkg::*;
#(
  parameter int              IR_W   = 8,
  parameter logic [IR_W-1:0] IDCODE = 8'hFE
) (
  input  logic            tck,
  input  logic            tap_rst,
  input  logic            tms,
  input  logic            tdi,
  input  logic            cfg_mode,
  input  logic            secure,
  output logic            tdo,
  output logic            tdo_en,
  output logic [IR_W-1:0] instr
);
  tap_st_e         st;
  tap_st_e         nxt;
  logic [IR_W-1:0] sr_q;

  jir_tap_fsm u_fsm (
    .tck(tck), .rst(tap_rst), .tms(tms), .st(st), .nxt(nxt)
  );

  jir_shift_path #(.IR_W(IR_W)) u_path (
    .tck(tck), .rst(tap_rst), .st(st), .tdi(tdi),
    .cfg_mode(cfg_mode), .secure(secure),
    .sr_q(sr_q), .tdo(tdo), .tdo_en(tdo_en)
  );

  jir_instr_hold #(.IR_W(IR_W), .IDCODE(IDCODE)) u_hold (
    .tck(tck), .rst(tap_rst), .nxt(nxt), .sr_q(sr_q), .instr(instr)
  );
endmodule

// File: rtl/jir_check.sv
module jir_check
  import jir_pkg::*;
#(
  parameter int              IR_W   = 8,
  parameter logic [IR_W-1:0] IDCODE = 8'hFE
) (
  input logic            tck,
  input logic            rst,
  input logic            tdi,
  input logic            cfg_mode,
  input logic            secure,
  input tap_st_e         st,
  input logic [IR_W-1:0] sr_q,
  input logic [IR_W-1:0] instr,
  input logic            tdo_en
);
  a_r1_capture_fixed: assert property (@(posedge tck) disable iff (rst)
    (st == ST_CAP_IR) |=> (sr_q[1:0] == 2'b01 && sr_q[2] == 1'b0 && sr_q[IR_W-1:5] == '0));

  a_r2_capture_status: assert property (@(posedge tck) disable iff (rst)
    (st == ST_CAP_IR) |=> (sr_q[4] == $past(cfg_mode) && sr_q[3] == $past(secure)));

  a_r3_shift_in_msb: assert property (@(posedge tck) disable iff (rst)
    (st == ST_SH_IR) |=> (sr_q[IR_W-1] == $past(tdi)));

  a_r5_enable_states: assert property (@(posedge tck) disable iff (rst)
    tdo_en == (st == ST_SH_IR || st == ST_SH_DR));

  a_r6_instr_hold: assert property (@(posedge tck) disable iff (rst)
    !$stable(instr) |-> (st == ST_UPD_IR || st == ST_TLR));

  a_r8_tlr_idcode: assert property (@(posedge tck) disable iff (rst)
    (st == ST_TLR) |-> (instr == IDCODE));
endmodule

bind jir_top jir_check #(.IR_W(IR_W), .IDCODE(IDCODE)) u_chk (
  .tck(tck), .rst(tap_rst), .tdi(tdi), .cfg_mode(cfg_mode), .secure(secure),
  .st(st), .sr_q(sr_q), .instr(instr), .tdo_en(tdo_en)
);

// File: tb/jir_top_test.sv
`timescale 1ns/1ps
module jir_top_test;
  logic       tck = 1'b0;
  logic       tap_rst = 1'b1;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic       cfg_mode = 1'b0;
  logic       secure = 1'b0;
  logic       tdo;
  logic       tdo_en;
  logic [7:0] instr;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 tck = ~tck;

  jir_top uut (
    .tck(tck), .tap_rst(tap_rst), .tms(tms), .tdi(tdi),
    .cfg_mode(cfg_mode), .secure(secure),
    .tdo(tdo), .tdo_en(tdo_en), .instr(instr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic step(input logic m);
    tms = m;
    tick();
  endtask

  // From Run-Test/Idle: scan n bits (8..16) of din into the IR, then back to idle.
  task automatic ir_scan(input logic [15:0] din, input int n, input logic cm, input logic sec);
    logic [7:0] cap;
    logic [7:0] prev;
    logic       exp_bit;
    prev     = instr;
    cfg_mode = cm;
    secure   = sec;
    cap      = {3'b000, cm, sec, 3'b001};
    step(1'b1);
    step(1'b1);
    step(1'b0);
    tms = 1'b0;
    @(posedge tck);
    #1;
    chk("R5 enable waits for falling edge", {15'd0, tdo_en}, 16'd0);
    @(negedge tck);
    #1;
    for (int k = 0; k < n; k++) begin
      exp_bit = (k < 8) ? cap[k] : din[k-8];
      chk((k < 8) ? "R1 R2 R3 captured bit" : "R4 delayed tdi bit", {15'd0, tdo}, {15'd0, exp_bit});
      chk("R5 enable in Shift-IR", {15'd0, tdo_en}, 16'd1);
      chk("R6 instr steady while shifting", {8'd0, instr}, {8'd0, prev});
      tdi = din[k];
      step(k == n - 1);
    end
    chk("R6 instr steady in Exit1-IR", {8'd0, instr}, {8'd0, prev});
    step(1'b1);
    chk((n > 8) ? "R4 last eight bits loaded" : "R3 instruction loaded", {8'd0, instr}, {8'd0, din[n-8 +: 8]});
    step(1'b0);
    chk("R5 enable low in idle", {15'd0, tdo_en}, 16'd0);
    chk("R5 tdo low in idle", {15'd0, tdo}, 16'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge tck);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] held;
    repeat (3) tick();
    chk("R7 reset instr", {8'd0, instr}, 16'h00FE);
    chk("R7 reset enable", {15'd0, tdo_en}, 16'd0);
    chk("R7 reset tdo", {15'd0, tdo}, 16'd0);
    tap_rst = 1'b0;
    step(1'b0);
    chk("R7 instr after leaving reset", {8'd0, instr}, 16'h00FE);

    // Exhaustive opcode sweep with all status-flag combinations
    for (int v = 0; v < 256; v++) begin
      ir_scan({8'h00, v[7:0]}, 8, v[0] ^ v[4], v[1] ^ v[6]);
    end

    // Long scans
    ir_scan(16'hB5A3, 11, 1'b1, 1'b0);
    ir_scan(16'h4C2E, 16, 1'b0, 1'b1);
    ir_scan(16'h003C, 8, 1'b1, 1'b1);

    // Data-register scan leaves the instruction alone
    held = instr;
    step(1'b1);
    step(1'b0);
    step(1'b0);
    chk("R5 enable in Shift-DR", {15'd0, tdo_en}, 16'd1);
    chk("R5 tdo low in Shift-DR", {15'd0, tdo}, 16'd0);
    step(1'b1);
    step(1'b1);
    step(1'b0);
    chk("R6 instr kept over DR scan", {8'd0, instr}, {8'd0, held});

    // Pause inside an instruction scan
    step(1'b1);
    step(1'b1);
    step(1'b0);
    step(1'b0);
    for (int k = 0; k < 3; k++) begin
      tdi = k[0];
      step(1'b0);
    end
    step(1'b1);
    step(1'b0);
    chk("R5 enable low in Pause-IR", {15'd0, tdo_en}, 16'd0);
    chk("R6 instr kept in Pause-IR", {8'd0, instr}, {8'd0, held});
    step(1'b0);
    chk("R6 instr kept while paused", {8'd0, instr}, {8'd0, held});
    step(1'b1);
    step(1'b0);
    chk("R5 enable back in Shift-IR", {15'd0, tdo_en}, 16'd1);
    chk("R6 instr kept after resume", {8'd0, instr}, {8'd0, held});
    step(1'b1);
    step(1'b1);
    step(1'b0);

    // Five TMS-high edges from Shift-DR
    ir_scan(16'h005A, 8, 1'b0, 1'b0);
    step(1'b1);
    step(1'b0);
    step(1'b0);
    for (int k = 0; k < 4; k++) step(1'b1);
    chk("R8 instr before fifth edge", {8'd0, instr}, 16'h005A);
    step(1'b1);
    chk("R8 instr on fifth edge", {8'd0, instr}, 16'h00FE);
    step(1'b0);

    // Reset in the middle of a scan
    ir_scan(16'h0033, 8, 1'b1, 1'b0);
    step(1'b1);
    step(1'b1);
    step(1'b0);
    step(1'b0);
    tap_rst = 1'b1;
    tick();
    chk("R7 mid-scan reset instr", {8'd0, instr}, 16'h00FE);
    chk("R7 mid-scan reset enable", {15'd0, tdo_en}, 16'd0);
    tap_rst = 1'b0;
    step(1'b0);
    ir_scan(16'h0081, 8, 1'b0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule